// File: doc/BRIEF.md
# Per-Context Interrupt Priority Selector

This block serves one interrupt target context. On every clock it looks at all interrupt sources and picks the one that should be presented to that context. The inputs are a pending vector, a claimed vector, the context's enable vector, one priority value per source and the context's priority threshold. The result is a source number, or 0 when nothing qualifies, together with a request line for the context.

The three bit vectors hold one bit per source, packed 32 sources to a word, so their width is the source count rounded up to a whole number of 32-bit words. Bit `s` of each vector belongs to source `s`. The priority bus carries `PRIO_WIDTH` bits per source, and source `s` occupies bits `[s*PRIO_WIDTH +: PRIO_WIDTH]`.

The selection is made by a balanced tree of compare stages. One output register follows the tree, so the source number and the request line show the inputs as they were sampled at the previous rising clock edge.

Top module: `ctx_prio_select`

## Requirements
- R1: A source counts as eligible only when its pending bit is 1, its claimed bit is 0 and its enable bit is 1.
- R2: An eligible source can be selected only when its priority is strictly greater than the threshold. A priority equal to the threshold never wins.
- R3: Among the qualifying sources, the one with the highest priority is selected. When priorities are equal, the lowest source number wins.
- R4: When no source qualifies, `win_id` is 0 and `irq` is 0.
- R5: `irq` is 1 exactly when `win_id` is nonzero. Both outputs are registered, reflect the inputs at the preceding rising edge, and are 0 while `rst_n` is low.
- R6: Vector bits at positions `NUM_SOURCES` and above, which fill the last 32-bit word, have no effect. `win_id` is always less than `NUM_SOURCES`.
- R7: Source 0 is never selected, whatever its pending, claimed and enable bits and its priority field hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears both outputs |
| pend_vec | input | 32*ceil(NUM_SOURCES/32) | Pending bit per source |
| claim_vec | input | 32*ceil(NUM_SOURCES/32) | Claimed (in service) bit per source |
| en_vec | input | 32*ceil(NUM_SOURCES/32) | Enable bit per source for this context |
| prio_vec | input | NUM_SOURCES*PRIO_WIDTH | Priority field per source |
| thresh | input | PRIO_WIDTH | Context priority threshold |
| win_id | output | clog2(NUM_SOURCES) | Selected source number, 0 for none |
| irq | output | 1 | Request line for the context |

## Verification
Two rules can apply in the same cycle: the threshold cut and the tie break toward the lowest source number. The bench provokes this by placing several eligible sources on one shared priority and then moving the threshold onto that priority and back below it. Once the threshold sits on the shared priority, every tied source must drop out. The bench also runs random cycles in which priorities are drawn from a narrow range, so ties and threshold matches occur often. Each cycle's outputs are compared against a behavioural scan that walks the sources in ascending order.

// File: rtl/ctx_prio_select.sv
module ctx_prio_select #(
  parameter int NUM_SOURCES = 40,
  parameter int PRIO_WIDTH  = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [32*((NUM_SOURCES+31)/32)-1:0] pend_vec,
  input  logic [32*((NUM_SOURCES+31)/32)-1:0] claim_vec,
  input  logic [32*((NUM_SOURCES+31)/32)-1:0] en_vec,
  input  logic [NUM_SOURCES*PRIO_WIDTH-1:0]   prio_vec,
  input  logic [PRIO_WIDTH-1:0]               thresh,
  output logic [$clog2(NUM_SOURCES > 1 ? NUM_SOURCES : 2)-1:0] win_id,
  output logic                              irq
);
  localparam int VEC_W  = 32*((NUM_SOURCES+31)/32);
  localparam int ID_W   = $clog2(NUM_SOURCES > 1 ? NUM_SOURCES : 2);
  localparam int DEPTH  = $clog2(NUM_SOURCES > 1 ? NUM_SOURCES : 2);
  localparam int LEAVES = 1 << DEPTH;

  for (genvar l = 0; l <= DEPTH; l++) begin : lvl
    localparam int NODES = LEAVES >> l;
    logic                  vld [NODES];
    logic [PRIO_WIDTH-1:0] pri [NODES];
    logic [ID_W-1:0]       id  [NODES];

    if (l == 0) begin : leaf
      for (genvar j = 0; j < NODES; j++) begin : src
        if (j != 0 && j < NUM_SOURCES) begin : real_src
          assign vld[j] = pend_vec[j] & ~claim_vec[j] & en_vec[j]
                          & (prio_vec[j*PRIO_WIDTH +: PRIO_WIDTH] > thresh);
          assign pri[j] = prio_vec[j*PRIO_WIDTH +: PRIO_WIDTH];
          assign id[j]  = ID_W'(j);
        end else begin : no_src
          assign vld[j] = 1'b0;
          assign pri[j] = '0;
          assign id[j]  = '0;
        end
      end
    end else begin : merge
      for (genvar j = 0; j < NODES; j++) begin : node
        logic take_hi;
        assign take_hi = lvl[l-1].vld[2*j+1] &
                         (~lvl[l-1].vld[2*j] | (lvl[l-1].pri[2*j+1] > lvl[l-1].pri[2*j]));
        assign vld[j] = lvl[l-1].vld[2*j] | lvl[l-1].vld[2*j+1];
        assign pri[j] = take_hi ? lvl[l-1].pri[2*j+1] : lvl[l-1].pri[2*j];
        assign id[j]  = take_hi ? lvl[l-1].id[2*j+1]  : lvl[l-1].id[2*j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_id <= '0;
      irq    <= 1'b0;
    end else begin
      win_id <= lvl[DEPTH].vld[0] ? lvl[DEPTH].id[0] : '0;
      irq    <= lvl[DEPTH].vld[0];
    end
  end

  logic unused_src0;
  assign unused_src0 = ^{pend_vec[0], claim_vec[0], en_vec[0],
                         prio_vec[PRIO_WIDTH-1:0], lvl[DEPTH].pri[0]};

  logic unused_pad;
  if (VEC_W > NUM_SOURCES) begin : g_pad
    assign unused_pad = ^{pend_vec[VEC_W-1:NUM_SOURCES], claim_vec[VEC_W-1:NUM_SOURCES],
                          en_vec[VEC_W-1:NUM_SOURCES]};
  end else begin : g_nopad
    assign unused_pad = 1'b0;
  end
endmodule

// File: rtl/ctx_prio_select_chk.sv
module ctx_prio_select_chk #(
  parameter int NUM_SOURCES = 40,
  parameter int PRIO_WIDTH  = 3
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [32*((NUM_SOURCES+31)/32)-1:0] pend_vec,
  input logic [32*((NUM_SOURCES+31)/32)-1:0] claim_vec,
  input logic [32*((NUM_SOURCES+31)/32)-1:0] en_vec,
  input logic [NUM_SOURCES*PRIO_WIDTH-1:0]   prio_vec,
  input logic [PRIO_WIDTH-1:0]               thresh,
  input logic [$clog2(NUM_SOURCES > 1 ? NUM_SOURCES : 2)-1:0] win_id,
  input logic                              irq
);
  localparam int VEC_W = 32*((NUM_SOURCES+31)/32);

  logic [VEC_W-1:0]                 c_pend, c_claim, c_en;
  logic [NUM_SOURCES*PRIO_WIDTH-1:0] c_prio;
  logic [PRIO_WIDTH-1:0]            c_thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_pend <= '0; c_claim <= '0; c_en <= '0; c_prio <= '0; c_thr <= '0;
    end else begin
      c_pend <= pend_vec; c_claim <= claim_vec; c_en <= en_vec;
      c_prio <= prio_vec; c_thr <= thresh;
    end
  end

  logic                  any_q, better, w_elig;
  logic [PRIO_WIDTH-1:0] w_pri;

  always_comb begin
    any_q  = 1'b0;
    better = 1'b0;
    w_pri  = '0;
    w_elig = 1'b0;
    if (int'(win_id) < NUM_SOURCES) begin
      w_pri  = c_prio[int'(win_id)*PRIO_WIDTH +: PRIO_WIDTH];
      w_elig = c_pend[int'(win_id)] & ~c_claim[int'(win_id)] & c_en[int'(win_id)];
    end
    for (int s = 0; s < NUM_SOURCES; s++) begin
      if (s != 0 && c_pend[s] && !c_claim[s] && c_en[s] &&
          c_prio[s*PRIO_WIDTH +: PRIO_WIDTH] > c_thr) begin
        any_q = 1'b1;
        if (win_id != '0 &&
            (c_prio[s*PRIO_WIDTH +: PRIO_WIDTH] > w_pri ||
             (c_prio[s*PRIO_WIDTH +: PRIO_WIDTH] == w_pri && s < int'(win_id))))
          better = 1'b1;
      end
    end
  end

  assert_winner_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win_id != '0 |-> w_elig);
  assert_above_thresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_id != '0 |-> w_pri > c_thr);
  assert_no_better_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !better);
  assert_empty_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !any_q |-> (win_id == '0 && !irq));
  assert_irq_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (win_id != '0));
  assert_id_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(win_id) < NUM_SOURCES);
  assert_found_when_any_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_q |-> win_id != '0);
endmodule

bind ctx_prio_select ctx_prio_select_chk #(.NUM_SOURCES(NUM_SOURCES), .PRIO_WIDTH(PRIO_WIDTH))
  u_chk (.*);

// File: tb/test_ctx_prio_select.sv
`timescale 1ns/1ps
module test_ctx_prio_select;
  localparam int N  = 40;
  localparam int PW = 3;
  localparam int VW = 32*((N+31)/32);
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VW-1:0] pend_vec = '0, claim_vec = '0, en_vec = '0;
  logic [N*PW-1:0] prio_vec = '0;
  logic [PW-1:0] thresh = '0;
  logic [IW-1:0] win_id;
  logic          irq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ctx_prio_select #(.NUM_SOURCES(N), .PRIO_WIDTH(PW)) i_ctx_prio_select (
    .clk(clk), .rst_n(rst_n), .pend_vec(pend_vec), .claim_vec(claim_vec),
    .en_vec(en_vec), .prio_vec(prio_vec), .thresh(thresh),
    .win_id(win_id), .irq(irq));

  function automatic int ref_pick();
    int best = int'(thresh);
    int pick = 0;
    for (int s = 1; s < N; s++) begin
      int p = int'(prio_vec[s*PW +: PW]);
      if (pend_vec[s] && !claim_vec[s] && en_vec[s] && p > best) begin
        best = p;
        pick = s;
      end
    end
    return pick;
  endfunction

  task automatic check(input int exp, input string tag);
    total++;
    if (int'(win_id) != exp || irq != (exp != 0)) begin
      bad++;
      $display("FAIL %s: id=%0d irq=%0d expected id=%0d irq=%0d", tag, win_id, irq, exp, exp != 0);
    end
  endtask

  task automatic step(input string tag);
    int exp = ref_pick();
    @(posedge clk);
    #1;
    check(exp, tag);
    @(negedge clk);
  endtask

  task automatic set_prio(input int s, input int p);
    prio_vec[s*PW +: PW] = PW'(p);
  endtask

  task automatic clear_all();
    pend_vec = '0; claim_vec = '0; en_vec = '0; prio_vec = '0; thresh = '0;
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog: expected id=done got hang");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R5: reset state with eligible inputs present
    pend_vec = '1; en_vec = '1;
    for (int s = 0; s < N; s++) set_prio(s, 7);
    repeat (3) @(posedge clk);
    #1;
    check(0, "R5 reset");
    @(negedge clk);
    rst_n = 1'b1;
    clear_all();
    step("R4 all zero");

    // R1: eligibility masks
    pend_vec[5] = 1; en_vec[5] = 1; set_prio(5, 3);
    step("R1 single eligible");
    claim_vec[5] = 1;
    step("R1 claimed masked");
    claim_vec[5] = 0; en_vec[5] = 0;
    step("R1 disabled masked");
    en_vec[5] = 1; pend_vec[5] = 0;
    step("R1 not pending");

    // R2 with R3: tie at threshold
    clear_all();
    for (int s = 10; s < 14; s++) begin
      pend_vec[s] = 1; en_vec[s] = 1; set_prio(s, 4);
    end
    thresh = 3;
    step("R3 tie lowest id");
    thresh = 4;
    step("R2 equal threshold cut");
    thresh = 3;
    set_prio(12, 5);
    step("R3 higher priority wins");
    set_prio(33, 5); pend_vec[33] = 1; en_vec[33] = 1;
    step("R3 tie across words");
    set_prio(35, 6); pend_vec[35] = 1; en_vec[35] = 1;
    step("R3 second word higher");

    // R6: pad bits set in last word
    clear_all();
    pend_vec[VW-1:N] = '1; en_vec[VW-1:N] = '1;
    step("R6 pad bits ignored");
    pend_vec[N-1] = 1; en_vec[N-1] = 1; set_prio(N-1, 1);
    step("R6 top source");

    // R7: source 0 never wins
    clear_all();
    pend_vec[0] = 1; en_vec[0] = 1; set_prio(0, 7);
    step("R7 source zero");
    pend_vec[1] = 1; en_vec[1] = 1; set_prio(1, 1);
    step("R7 source one beats zero");

    // random, narrow priorities for many ties
    for (int i = 0; i < 3000; i++) begin
      int lo = (i % 2 == 0) ? 0 : 5;
      for (int w = 0; w < VW/32; w++) begin
        pend_vec[w*32 +: 32]  = $urandom();
        claim_vec[w*32 +: 32] = $urandom() & $urandom();
        en_vec[w*32 +: 32]    = $urandom() | $urandom();
      end
      for (int s = 0; s < N; s++) set_prio(s, $urandom_range(lo, 7));
      thresh = PW'($urandom_range(lo, 7));
      step("R3 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule